// File: doc/BRIEF.md
# Conditionally reversible bit-operation unit

This unit holds a small array of single-bit nodes and applies one micro-operation per accepted command. Each micro-operation is a conditionally reversible variant of a familiar bit operation. These are: unconditional set and clear, set and clear gated by a control node, copy and inverted copy into an empty node, a two-input AND into an empty node, and the undo forms that return a target node to 0. Each operation has a starting condition under which it is reversible. The unit checks that condition against the node values held before the command, and it writes the correct end value in every case.

When the starting condition does not hold, the operation would need a dissipative step. The unit then raises a dissipation flag for that command and increments a saturating counter. A surrounding controller issues sequences of these micro-operations, such as a multi-step controlled-NOT built entirely from primitives. The flag and the counter show whether the sequence stayed within its reversible starting conditions.

Commands arrive on a valid/ready handshake. Each command carries a 4-bit opcode and three node indices: a first source or control node (X), a second source node (Y) and a target node (D). Only the target node is ever written.

Top module: `rbu_unit`

## Requirements
- R1: After reset, every node reads 0, the dissipation count is 0, the flag is 0 and ready is 1.
- R2: A command is taken at a rising edge where valid and ready are both 1. Ready is 0 for the one cycle after that edge and is then 1 again. A valid command presented while ready is 0 changes nothing.
- R3: Opcode 0 (unconditional set) leaves D at 1. It is dissipative exactly when D was already 1.
- R4: Opcode 1 (unconditional clear) leaves D at 0. It is dissipative exactly when D was already 0.
- R5: Opcode 2 (gated set) and opcode 3 (gated clear) do nothing and raise no flag when node X is 0. When X is 1, opcode 2 sets D and is dissipative if D was 1, and opcode 3 clears D and is dissipative if D was 0.
- R6: Opcode 4 (latch) writes X into D and opcode 6 (inverted copy) writes the complement of X into D. Each is dissipative when D was 1 before the command.
- R7: Opcode 5 (unlatch) and opcode 7 (inverted uncopy) leave D at 0. Opcode 5 is dissipative when D differed from X, and opcode 7 is dissipative when D differed from the complement of X.
- R8: Opcode 8 writes X AND Y into D and is dissipative when D was 1. Opcode 9 clears D and is dissipative when D differed from X AND Y.
- R9: Every condition and every written value uses the node values held before the command, including when X, Y and D name the same node.
- R10: The 16-bit dissipation count rises by one for each dissipative command and holds at 0xFFFF once it reaches that value.
- R11: The flag shows whether the most recently accepted command was dissipative, and it holds that value until the next command is accepted.
- R12: Opcodes 10 to 15 change no node, clear the flag and leave the count unchanged.
- R13: The fixed 16-command controlled-NOT sequence leaves b = a XOR b and a unchanged, and returns its six scratch nodes to 0. It raises no flag for any of the four (a, b) starting values.
- R14: A command changes no node other than D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 4 | Micro-operation code |
| cmd_x | input | 4 | First source or control node index |
| cmd_y | input | 4 | Second source node index |
| cmd_d | input | 4 | Target node index |
| node_q | output | 16 | Node array, bit n is node n |
| diss_flag | output | 1 | Last accepted command was dissipative |
| diss_count | output | 16 | Saturating count of dissipative commands |

## Verification
Node values, the flag and the count all update at the same rising edge that accepts a command. Ready falls at that edge and rises again at the following one. The bench drives each command at a falling edge and removes valid at the next falling edge. It samples every result at that falling edge, which is one edge after acceptance. The ignored-command check presents valid only during the cycle in which ready is 0 and samples after the edge at which the command would have been accepted. The saturation check counts accepted dissipative commands one by one, so it can compare the count to 0xFFFE and 0xFFFF at exactly the edges where those values are due.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_RSET     = 4'd0,
      OP_RCLR     = 4'd1,
      OP_CSET     = 4'd2,
      OP_CCLR     = 4'd3,
      OP_LATCH    = 4'd4,
      OP_UNLATCH  = 4'd5,
      OP_CPYINV   = 4'd6,
      OP_UNCPYINV = 4'd7,
      OP_AND      = 4'd8,
      OP_UNAND    = 4'd9
   } rbu_op_e;

   localparam logic [OP_W-1:0] OP_LAST_DEFINED = 4'd9;
endpackage

// File: rtl/rbu_op_eval.sv
// Pure evaluation of one micro-operation from the pre-command node values.
module rbu_op_eval
   import rbu_pkg::*;
(
   input  logic [OP_W-1:0] op,
   input  logic            vx,
   input  logic            vy,
   input  logic            vd,
   output logic            wr_en,
   output logic            wr_val,
   output logic            dissip
);
   always_comb begin
      wr_en  = 1'b1;
      wr_val = 1'b0;
      dissip = 1'b0;
      case (op)
         OP_RSET:     begin wr_val = 1'b1;       dissip = vd;               end
         OP_RCLR:     begin wr_val = 1'b0;       dissip = ~vd;              end
         OP_CSET:     begin wr_en  = vx; wr_val = 1'b1; dissip = vx & vd;  end
         OP_CCLR:     begin wr_en  = vx; wr_val = 1'b0; dissip = vx & ~vd; end
         OP_LATCH:    begin wr_val = vx;         dissip = vd;               end
         OP_UNLATCH:  begin wr_val = 1'b0;       dissip = vd ^ vx;          end
         OP_CPYINV:   begin wr_val = ~vx;        dissip = vd;               end
         OP_UNCPYINV: begin wr_val = 1'b0;       dissip = vd ^ ~vx;         end
         OP_AND:      begin wr_val = vx & vy;    dissip = vd;               end
         OP_UNAND:    begin wr_val = 1'b0;       dissip = vd ^ (vx & vy);   end
         default:     begin wr_en  = 1'b0;       dissip = 1'b0;             end
      endcase
   end

   // R12: an undefined code neither writes nor flags
   always_comb begin
      if (op > OP_LAST_DEFINED)
         p_reserved_inert_r12: assert (!wr_en && !dissip);
   end
endmodule

// File: rtl/rbu_node_file.sv
// Array of single-bit nodes: three read ports, one bit-write port.
module rbu_node_file #(
   parameter  int NODES = 16,
   localparam int IDX_W = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] rx,
   input  logic [IDX_W-1:0] ry,
   input  logic [IDX_W-1:0] rd,
   output logic             vx,
   output logic             vy,
   output logic             vd,
   input  logic             we,
   input  logic             wval,
   output logic [NODES-1:0] q
);
   assign vx = q[rx];
   assign vy = q[ry];
   assign vd = q[rd];

   for (genvar n = 0; n < NODES; n++) begin : g_node
      always_ff @(posedge clk) begin
         if (rst)
            q[n] <= 1'b0;
         else if (we && (rd == IDX_W'(n)))
            q[n] <= wval;
      end
   end

   // R14: at most one node changes per clock
   p_single_node_r14: assert property (@(posedge clk) disable iff (rst)
      $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/rbu_sat_counter.sv
// Event counter; SATURATE picks holding at all-ones or wrapping.
module rbu_sat_counter #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TOP = '1;

   if (W < 1) begin : g_bad_width
      $error("rbu_sat_counter: W must be at least 1");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (rst)
            count <= '0;
         else if (inc && (count != TOP))
            count <= count + 1'b1;
      end

      // R10: once full the count stays full
      p_sat_hold_r10: assert property (@(posedge clk) disable iff (rst)
         (count == TOP) |=> (count == TOP));
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (rst)
            count <= '0;
         else if (inc)
            count <= count + 1'b1;
      end
   end

   // R10: one step per event below the top
   p_step_r10: assert property (@(posedge clk) disable iff (rst)
      (inc && (count != TOP)) |=> (count == W'($past(count) + 1'b1)));
   p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      !inc |=> $stable(count));
endmodule

// File: rtl/rbu_unit.sv
// Conditionally reversible bit-operation unit: top level.
module rbu_unit
   import rbu_pkg::*;
#(
   parameter  int NODES    = 16,
   parameter  int CNT_W    = 16,
   parameter  bit SATURATE = 1'b1,
   localparam int IDX_W    = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [OP_W-1:0]  cmd_op,
   input  logic [IDX_W-1:0] cmd_x,
   input  logic [IDX_W-1:0] cmd_y,
   input  logic [IDX_W-1:0] cmd_d,
   output logic [NODES-1:0] node_q,
   output logic             diss_flag,
   output logic [CNT_W-1:0] diss_count
);
   if ((NODES < 2) || ((1 << IDX_W) != NODES)) begin : g_bad_nodes
      $error("rbu_unit: NODES must be a power of two of at least 2");
   end

   logic accept;
   logic vx, vy, vd;
   logic wr_en, wr_val, dissip;

   assign accept = cmd_valid && cmd_ready;

   rbu_node_file #(.NODES(NODES)) u_nodes (
      .clk  (clk),
      .rst  (rst),
      .rx   (cmd_x),
      .ry   (cmd_y),
      .rd   (cmd_d),
      .vx   (vx),
      .vy   (vy),
      .vd   (vd),
      .we   (accept && wr_en),
      .wval (wr_val),
      .q    (node_q)
   );

   rbu_op_eval u_eval (
      .op     (cmd_op),
      .vx     (vx),
      .vy     (vy),
      .vd     (vd),
      .wr_en  (wr_en),
      .wr_val (wr_val),
      .dissip (dissip)
   );

   rbu_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk   (clk),
      .rst   (rst),
      .inc   (accept && dissip),
      .count (diss_count)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_ready <= 1'b1;
         diss_flag <= 1'b0;
      end else begin
         cmd_ready <= !accept;
         if (accept)
            diss_flag <= dissip;
      end
   end

   // R2: ready drops for exactly one cycle after each command
   p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
      accept |=> !cmd_ready);
   p_ready_back_r2: assert property (@(posedge clk) disable iff (rst)
      !cmd_ready |=> cmd_ready);
   p_idle_nodes_r2: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable(node_q));
   // R11: flag only moves on an accepted command
   p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable(diss_flag));
   // R3: unconditional set always ends at 1
   p_set_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (accept && (cmd_op == OP_RSET)) |=> node_q[$past(cmd_d)]);
   // R4: unconditional clear always ends at 0
   p_clr_lands_r4: assert property (@(posedge clk) disable iff (rst)
      (accept && (cmd_op == OP_RCLR)) |=> !node_q[$past(cmd_d)]);
   // R12: undefined codes leave the array alone and clear the flag
   p_reserved_r12: assert property (@(posedge clk) disable iff (rst)
      (accept && (cmd_op > OP_LAST_DEFINED)) |=> ($stable(node_q) && !diss_flag));
endmodule

// File: tb/sim_rbu_unit.sv
module sim_rbu_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 29;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [3:0]  cmd_op = '0, cmd_x = '0, cmd_y = '0, cmd_d = '0;
   logic [15:0] node_q;
   logic        diss_flag;
   logic [15:0] diss_count;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rbu_unit u0 (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_d(cmd_d),
      .node_q(node_q), .diss_flag(diss_flag), .diss_count(diss_count)
   );

   // {op, x, y, d, expected nodes, expected flag}, applied in order from reset
   localparam logic [32:0] VEC [NV] = '{
      {4'd0, 4'd0, 4'd0, 4'd3,  16'h0008, 1'b0},  // R3
      {4'd0, 4'd0, 4'd0, 4'd3,  16'h0008, 1'b1},  // R3 already 1
      {4'd1, 4'd0, 4'd0, 4'd3,  16'h0000, 1'b0},  // R4
      {4'd1, 4'd0, 4'd0, 4'd3,  16'h0000, 1'b1},  // R4 already 0
      {4'd0, 4'd0, 4'd0, 4'd1,  16'h0002, 1'b0},  // R3
      {4'd2, 4'd0, 4'd0, 4'd5,  16'h0002, 1'b0},  // R5 control 0
      {4'd2, 4'd1, 4'd0, 4'd5,  16'h0022, 1'b0},  // R5
      {4'd2, 4'd1, 4'd0, 4'd5,  16'h0022, 1'b1},  // R5 set on 1
      {4'd3, 4'd1, 4'd0, 4'd5,  16'h0002, 1'b0},  // R5
      {4'd3, 4'd1, 4'd0, 4'd5,  16'h0002, 1'b1},  // R5 clear on 0
      {4'd4, 4'd1, 4'd0, 4'd7,  16'h0082, 1'b0},  // R6 latch
      {4'd6, 4'd1, 4'd0, 4'd8,  16'h0082, 1'b0},  // R6 inverted copy of 1
      {4'd6, 4'd0, 4'd0, 4'd9,  16'h0282, 1'b0},  // R6 inverted copy of 0
      {4'd4, 4'd0, 4'd0, 4'd9,  16'h0082, 1'b1},  // R6 latch onto a 1
      {4'd5, 4'd1, 4'd0, 4'd7,  16'h0002, 1'b0},  // R7 matched unlatch
      {4'd5, 4'd1, 4'd0, 4'd7,  16'h0002, 1'b1},  // R7 mismatched unlatch
      {4'd6, 4'd0, 4'd0, 4'd10, 16'h0402, 1'b0},  // R6
      {4'd7, 4'd0, 4'd0, 4'd10, 16'h0002, 1'b0},  // R7 matched inverted uncopy
      {4'd8, 4'd1, 4'd1, 4'd11, 16'h0802, 1'b0},  // R8
      {4'd8, 4'd1, 4'd0, 4'd12, 16'h0802, 1'b0},  // R8
      {4'd9, 4'd1, 4'd0, 4'd11, 16'h0002, 1'b1},  // R8 mismatched undo
      {4'd8, 4'd1, 4'd1, 4'd11, 16'h0802, 1'b0},  // R8
      {4'd9, 4'd1, 4'd1, 4'd11, 16'h0002, 1'b0},  // R8 matched undo
      {4'd8, 4'd1, 4'd1, 4'd1,  16'h0002, 1'b1},  // R9 alias, target was 1
      {4'd2, 4'd2, 4'd0, 4'd2,  16'h0002, 1'b0},  // R9 alias, control 0
      {4'd3, 4'd1, 4'd0, 4'd1,  16'h0000, 1'b0},  // R9 alias, clear own 1
      {4'd12, 4'd0, 4'd0, 4'd4, 16'h0000, 1'b0},  // R12
      {4'd0, 4'd0, 4'd0, 4'd15, 16'h8000, 1'b0},  // R3 top index
      {4'd15, 4'd0, 4'd0, 4'd15, 16'h8000, 1'b0}  // R12
   };
   localparam int VREQ [NV] = '{3,3,4,4,3,5,5,5,5,5,6,6,6,6,7,7,6,7,8,8,8,8,8,9,9,9,12,3,12};

   // controlled-NOT on a=0, b=1; scratch 2..7. {op, x, y, d}
   localparam logic [15:0] MAC [16] = '{
      {4'd8, 4'd0, 4'd1, 4'd2}, {4'd6, 4'd0, 4'd0, 4'd3},
      {4'd8, 4'd3, 4'd1, 4'd4}, {4'd3, 4'd2, 4'd0, 4'd1},
      {4'd3, 4'd4, 4'd0, 4'd1}, {4'd6, 4'd2, 4'd0, 4'd5},
      {4'd8, 4'd0, 4'd5, 4'd6}, {4'd2, 4'd4, 4'd0, 4'd1},
      {4'd2, 4'd6, 4'd0, 4'd1}, {4'd9, 4'd0, 4'd1, 4'd6},
      {4'd9, 4'd3, 4'd1, 4'd4}, {4'd7, 4'd2, 4'd0, 4'd5},
      {4'd6, 4'd1, 4'd0, 4'd7}, {4'd9, 4'd0, 4'd7, 4'd2},
      {4'd7, 4'd1, 4'd0, 4'd7}, {4'd7, 4'd0, 4'd0, 4'd3}
   };

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // drive at a falling edge, accepted at the next rising edge, results at the next falling edge
   task automatic send(input logic [3:0] op, input logic [3:0] x, input logic [3:0] y, input logic [3:0] d);
      @(negedge clk);
      cmd_op = op; cmd_x = x; cmd_y = y; cmd_d = d; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int exp_cnt;
      int flags_seen;
      logic [15:0] cnt_before;
      do_reset();
      // R1 reset state
      check("R1 nodes", 32'(node_q), 32'h0);
      check("R1 count", 32'(diss_count), 32'h0);
      check("R1 flag", 32'(diss_flag), 32'h0);
      check("R1 ready", 32'(cmd_ready), 32'h1);

      // R2 handshake: ready low one cycle, valid during that cycle ignored
      send(4'd0, 4'd0, 4'd0, 4'd3);
      check("R2 ready low after accept", 32'(cmd_ready), 32'h0);
      cmd_op = 4'd0; cmd_d = 4'd14; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R2 ready back", 32'(cmd_ready), 32'h1);
      check("R2 ignored command", 32'(node_q), 32'h0008);
      send(4'd1, 4'd0, 4'd0, 4'd3);
      check("R2 restore", 32'(node_q), 32'h0000);

      // table walk
      exp_cnt = 0;
      for (int v = 0; v < NV; v++) begin
         send(VEC[v][32:29], VEC[v][28:25], VEC[v][24:21], VEC[v][20:17]);
         if (VEC[v][0]) exp_cnt++;
         check($sformatf("R%0d vector %0d nodes", VREQ[v], v), 32'(node_q), 32'(VEC[v][16:1]));
         check($sformatf("R%0d vector %0d flag", VREQ[v], v), 32'(diss_flag), 32'(VEC[v][0]));
         check($sformatf("R10 vector %0d count", v), 32'(diss_count), 32'(exp_cnt));
      end

      // R11 flag holds across idle cycles
      send(4'd0, 4'd0, 4'd0, 4'd15);
      exp_cnt++;
      repeat (3) @(negedge clk);
      check("R11 flag held", 32'(diss_flag), 32'h1);
      check("R10 count after hold", 32'(diss_count), 32'(exp_cnt));
      send(4'd1, 4'd0, 4'd0, 4'd15);
      check("R14 cleared top node", 32'(node_q), 32'h0);

      // R13 controlled-NOT macro over all four inputs
      for (int ab = 0; ab < 4; ab++) begin
         if (ab[0]) send(4'd0, 4'd0, 4'd0, 4'd0);
         if (ab[1]) send(4'd0, 4'd0, 4'd0, 4'd1);
         cnt_before = diss_count;
         flags_seen = 0;
         for (int s = 0; s < 16; s++) begin
            send(MAC[s][15:12], MAC[s][11:8], MAC[s][7:4], MAC[s][3:0]);
            if (diss_flag) flags_seen++;
         end
         check($sformatf("R13 a=%0d b=%0d nodes", ab[0], ab[1]), 32'(node_q),
               32'({ab[0] ^ ab[1], ab[0]}));
         check("R13 no flag in sequence", 32'(flags_seen), 32'h0);
         check("R13 count unchanged", 32'(diss_count), 32'(cnt_before));
         if (ab[0]) send(4'd1, 4'd0, 4'd0, 4'd0);
         if (ab[0] ^ ab[1]) send(4'd1, 4'd0, 4'd0, 4'd1);
      end

      // R10 saturation
      do_reset();
      check("R1 count after second reset", 32'(diss_count), 32'h0);
      send(4'd0, 4'd0, 4'd0, 4'd0);
      for (int k = 0; k < 65534; k++) send(4'd0, 4'd0, 4'd0, 4'd0);
      check("R10 count just below top", 32'(diss_count), 32'hFFFE);
      send(4'd0, 4'd0, 4'd0, 4'd0);
      check("R10 count reaches top", 32'(diss_count), 32'hFFFF);
      for (int k = 0; k < 3; k++) send(4'd0, 4'd0, 4'd0, 4'd0);
      check("R10 count saturated", 32'(diss_count), 32'hFFFF);
      check("R11 flag on saturated run", 32'(diss_flag), 32'h1);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule